// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block is the digital division chain of one synthesizer channel. A fast clock running at the oscillator-under-control rate is divided by a total ratio of P·N + A. A dual-modulus prescaler, modelled as a synchronous counter, divides by P+1 while a swallow counter still holds a non-zero count. After that it divides by P. An 11-bit main counter counts prescaler cycles. P is 64 or 128, picked by a modulus-select bit.

A separate 14-bit reference counter divides the oscillator clock by R. The two pulses, the comparison pulse `fp` and the reference pulse `fr`, feed a phase comparator outside this block. Divide values come from holding registers outside the block. They are sampled only at the end of each output period, so a write never produces a short or torn period.

A power-save input parks both counters at the start of a period. A value that is not allowed raises an error flag, and the divider keeps running with a defined ratio.

Top module: `psw_divider`

## Requirements
- R1: With `mod_sel` = 1 (P = 64), `fp` pulses every 64·N + A cycles of `vco_clk` when A < N.
- R2: With `mod_sel` = 0 (P = 128), `fp` pulses every 128·N + A cycles of `vco_clk` when A < N.
- R3: `fp` and `fr` are each high for exactly one cycle of their own clock per period, for all allowed values.
- R4: `fr` pulses every R cycles of `osc_clk`.
- R5: New N, A, `mod_sel` or R values that arrive during a period do not change that period. They set the length of the period that starts at the next pulse.
- R6: While `pwr_save` is 1, `fp` and `fr` stay 0 and the counters are held. After `pwr_save` falls, the first clock edge loads the divide values, and the first `fp` follows P·N + A edges later.
- R7: While `rst_n` is 0, `fp`, `fr`, `err_n` and `err_r` are 0.
- R8: At each load, `err_n` is set to 1 if N < 5 or A ≥ N, and otherwise to 0. Likewise `err_r` is set to 1 if R < 5, and otherwise to 0. Each flag holds its value until the next load in its own clock domain.
- R9: With values that are not allowed, the division continues. N = 0 acts as N = 1, and R = 0 acts as R = 1. When A ≥ N, every one of the N prescaler cycles uses P+1, so the period is (P+1)·N.

Ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Fast clock to be divided |
| osc_clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_save | input | 1 | 1 holds both counters idle |
| mod_sel | input | 1 | Prescaler pair: 1 selects 64/65, 0 selects 128/129 |
| n_val | input | 11 | Main count N |
| a_val | input | 7 | Swallow count A |
| r_val | input | 14 | Reference count R |
| fp | output | 1 | Comparison pulse, `vco_clk` domain |
| fr | output | 1 | Reference pulse, `osc_clk` domain |
| err_n | output | 1 | Loaded N/A values not allowed |
| err_r | output | 1 | Loaded R value not allowed |

## Verification
The bench targets three kinds of corner case:

- **Moment a new value takes effect.** Values are changed right after a pulse. A design that reloads in the middle of a period would give a period that mixes the old and new ratios.
- **Modulus switching.** Both prescaler pairs are run, and A = 0 is included. A design that switches the modulus one prescaler cycle late, or on the wrong count, is off by whole units of P or by one.
- **Restart from power save and values that are not allowed.** N = 0, R = 0, A ≥ N and N < 5 are all run. A design without clamping would stall or never pulse, and a wrongly timed error flag would not match the value that was loaded.

// File: rtl/psw_divider.sv
module psw_divider #(
  parameter int NW      = 11,
  parameter int AW      = 7,
  parameter int RW      = 14,
  parameter int P_LO    = 64,
  parameter int P_HI    = 128,
  parameter int MIN_CNT = 5,
  localparam int PW     = $clog2(P_HI + 1)
) (
  input  logic          vco_clk,
  input  logic          osc_clk,
  input  logic          rst_n,
  input  logic          pwr_save,
  input  logic          mod_sel,
  input  logic [NW-1:0] n_val,
  input  logic [AW-1:0] a_val,
  input  logic [RW-1:0] r_val,
  output logic          fp,
  output logic          fr,
  output logic          err_n,
  output logic          err_r
);

  localparam logic [PW-1:0] TOP_LO = PW'(P_LO - 1);
  localparam logic [PW-1:0] TOP_HI = PW'(P_HI - 1);

  logic [PW-1:0] pre_cnt;
  logic [AW-1:0] sw_cnt;
  logic [NW-1:0] main_cnt;
  logic          small_p;
  logic [RW-1:0] r_cnt;

  wire [PW-1:0] pre_top  = (small_p ? TOP_LO : TOP_HI) + PW'(sw_cnt != '0);
  wire          pre_wrap = pre_cnt == pre_top;
  wire          bound    = pre_wrap && (main_cnt == NW'(1));
  wire          fp_load  = (main_cnt == '0) || bound;
  wire [NW-1:0] n_eff    = (n_val == '0) ? NW'(1) : n_val;
  wire          n_bad    = (n_val < NW'(MIN_CNT)) || (NW'(a_val) >= n_val);

  always_ff @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      sw_cnt   <= '0;
      main_cnt <= '0;
      small_p  <= 1'b0;
      fp       <= 1'b0;
      err_n    <= 1'b0;
    end else if (pwr_save) begin
      pre_cnt  <= '0;
      sw_cnt   <= '0;
      main_cnt <= '0;
      fp       <= 1'b0;
    end else if (fp_load) begin
      pre_cnt  <= '0;
      sw_cnt   <= a_val;
      main_cnt <= n_eff;
      small_p  <= mod_sel;
      err_n    <= n_bad;
      fp       <= bound;
    end else begin
      fp <= 1'b0;
      if (pre_wrap) begin
        pre_cnt  <= '0;
        main_cnt <= main_cnt - NW'(1);
        if (sw_cnt != '0) sw_cnt <= sw_cnt - AW'(1);
      end else begin
        pre_cnt <= pre_cnt + PW'(1);
      end
    end
  end

  wire          r_end  = r_cnt == RW'(1);
  wire          r_load = (r_cnt == '0) || r_end;
  wire [RW-1:0] r_eff  = (r_val == '0) ? RW'(1) : r_val;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      r_cnt <= '0;
      fr    <= 1'b0;
      err_r <= 1'b0;
    end else if (pwr_save) begin
      r_cnt <= '0;
      fr    <= 1'b0;
    end else if (r_load) begin
      r_cnt <= r_eff;
      err_r <= r_val < RW'(MIN_CNT);
      fr    <= r_end;
    end else begin
      r_cnt <= r_cnt - RW'(1);
      fr    <= 1'b0;
    end
  end

endmodule

module psw_divider_chk #(
  parameter int NW = 11,
  parameter int AW = 7,
  parameter int RW = 14,
  parameter int MIN_CNT = 5
) (
  input logic          vco_clk,
  input logic          osc_clk,
  input logic          rst_n,
  input logic          pwr_save,
  input logic [NW-1:0] n_val,
  input logic [AW-1:0] a_val,
  input logic          fp,
  input logic          fr,
  input logic          err_n,
  input logic          err_r
);

  // R3
  fp_single_chk: assert property (@(posedge vco_clk) disable iff (!rst_n)
    fp |=> !fp);

  // R3
  fr_single_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (fr && !err_r) |=> !fr);

  // R6
  ps_fp_quiet_chk: assert property (@(posedge vco_clk) disable iff (!rst_n)
    pwr_save |=> !fp);

  // R6
  ps_fr_quiet_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    pwr_save |=> !fr);

  // R8
  err_n_match_chk: assert property (@(posedge vco_clk) disable iff (!rst_n)
    fp |-> (err_n == $past((n_val < NW'(MIN_CNT)) || (NW'(a_val) >= n_val))));

  // R7
  reset_quiet_chk: assert property (@(posedge vco_clk)
    !rst_n |-> (!fp && !fr && !err_n && !err_r));

endmodule

bind psw_divider psw_divider_chk #(.NW(NW), .AW(AW), .RW(RW), .MIN_CNT(MIN_CNT)) u_psw_divider_chk (
  .vco_clk(vco_clk), .osc_clk(osc_clk), .rst_n(rst_n), .pwr_save(pwr_save),
  .n_val(n_val), .a_val(a_val), .fp(fp), .fr(fr), .err_n(err_n), .err_r(err_r)
);

// File: tb/test_psw_divider.sv
`timescale 1ns/1ps
module test_psw_divider;
  logic vco_clk = 1'b0, osc_clk = 1'b0;
  logic rst_n = 1'b0, pwr_save = 1'b0, mod_sel = 1'b1;
  logic [10:0] n_val = 11'd5;
  logic [6:0]  a_val = 7'd2;
  logic [13:0] r_val = 14'd6;
  logic fp, fr, err_n, err_r;

  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R7";
  bit done = 1'b0;

  always #10 vco_clk = ~vco_clk;
  always #17 osc_clk = ~osc_clk;

  psw_divider i_psw_divider (
    .vco_clk(vco_clk), .osc_clk(osc_clk), .rst_n(rst_n), .pwr_save(pwr_save),
    .mod_sel(mod_sel), .n_val(n_val), .a_val(a_val), .r_val(r_val),
    .fp(fp), .fr(fr), .err_n(err_n), .err_r(err_r)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int fp_ratio(bit sel, int n, int a);
    int nf = (n == 0) ? 1 : n;
    int p  = sel ? 64 : 128;
    return p * nf + ((a < nf) ? a : nf);
  endfunction

  // behavioural reference, vco domain
  bit ld_f = 0, e_fp = 0, e_errn = 0;
  int rem_f = 0;
  always @(posedge vco_clk) begin
    if (!rst_n || pwr_save) begin
      ld_f = 0; e_fp = 0;
      if (!rst_n) e_errn = 0;
    end else if (!ld_f) begin
      ld_f = 1; e_fp = 0;
      rem_f = fp_ratio(mod_sel, n_val, a_val);
      e_errn = (n_val < 5) || (a_val >= n_val);
    end else begin
      rem_f--;
      if (rem_f == 0) begin
        e_fp = 1;
        rem_f = fp_ratio(mod_sel, n_val, a_val);
        e_errn = (n_val < 5) || (a_val >= n_val);
      end else e_fp = 0;
    end
  end

  // behavioural reference, osc domain
  bit ld_r = 0, e_fr = 0, e_errr = 0;
  int rem_r = 0;
  always @(posedge osc_clk) begin
    if (!rst_n || pwr_save) begin
      ld_r = 0; e_fr = 0;
      if (!rst_n) e_errr = 0;
    end else if (!ld_r) begin
      ld_r = 1; e_fr = 0;
      rem_r = (r_val == 0) ? 1 : r_val;
      e_errr = r_val < 5;
    end else begin
      rem_r--;
      if (rem_r == 0) begin
        e_fr = 1;
        rem_r = (r_val == 0) ? 1 : r_val;
        e_errr = r_val < 5;
      end else e_fr = 0;
    end
  end

  always @(negedge vco_clk) if (!done) begin
    chk({cur_req, " fp"}, fp, e_fp);
    chk({cur_req, " err_n"}, err_n, e_errn);
  end

  always @(negedge osc_clk) if (!done) begin
    chk({cur_req, " fr"}, fr, e_fr);
    chk({cur_req, " err_r"}, err_r, e_errr);
  end

  task automatic fp_period(output int n);
    @(negedge vco_clk);
    while (!fp) @(negedge vco_clk);
    n = 0;
    do begin @(negedge vco_clk); n++; end while (!fp);
  endtask

  task automatic fr_period(output int n);
    @(negedge osc_clk);
    while (!fr) @(negedge osc_clk);
    n = 0;
    do begin @(negedge osc_clk); n++; end while (!fr);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge vco_clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  initial begin
    int per;
    repeat (5) @(negedge vco_clk);
    chk("R7 fp in reset", fp, 0);
    chk("R7 fr in reset", fr, 0);
    chk("R7 err_n in reset", err_n, 0);
    chk("R7 err_r in reset", err_r, 0);
    rst_n = 1'b1;

    cur_req = "R1";
    fp_period(per); chk("R1 period N=5 A=2", per, 322);
    n_val = 11'd7; a_val = 7'd0;
    fp_period(per); fp_period(per); chk("R1 period N=7 A=0", per, 448);

    cur_req = "R2";
    mod_sel = 1'b0; n_val = 11'd6; a_val = 7'd3;
    fp_period(per); fp_period(per); chk("R2 period N=6 A=3", per, 771);

    cur_req = "R4";
    fr_period(per); chk("R4 period R=6", per, 6);
    @(negedge vco_clk); r_val = 14'd11;
    fr_period(per); fr_period(per); chk("R4 period R=11", per, 11);

    cur_req = "R5";
    mod_sel = 1'b1; n_val = 11'd5; a_val = 7'd2;
    fp_period(per); fp_period(per); chk("R5 settle", per, 322);
    @(negedge vco_clk); while (!fp) @(negedge vco_clk);
    repeat (20) @(negedge vco_clk);
    n_val = 11'd9; a_val = 7'd4;
    per = 20;
    while (!fp) begin @(negedge vco_clk); per++; end
    chk("R5 period in flight keeps old ratio", per, 322);
    fp_period(per); chk("R5 next period uses new ratio", per, 580);
    @(negedge osc_clk); while (!fr) @(negedge osc_clk);
    repeat (3) @(negedge osc_clk);
    r_val = 14'd7;
    per = 3;
    while (!fr) begin @(negedge osc_clk); per++; end
    chk("R5 ref period in flight keeps old R", per, 11);
    fr_period(per); chk("R5 ref next period uses new R", per, 7);

    cur_req = "R6";
    @(negedge vco_clk); pwr_save = 1'b1;
    repeat (60) @(negedge vco_clk);
    chk("R6 fp held low", fp, 0);
    chk("R6 fr held low", fr, 0);
    pwr_save = 1'b0;
    per = 0;
    do begin @(negedge vco_clk); per++; end while (!fp);
    chk("R6 first pulse after wake", per, 581);

    cur_req = "R8";
    n_val = 11'd3; a_val = 7'd1;
    fp_period(per);
    chk("R8 err_n set for N=3", err_n, 1);
    fp_period(per);
    cur_req = "R9";
    chk("R9 N=3 still divides", per, 193);
    n_val = 11'd6; a_val = 7'd9;
    fp_period(per); fp_period(per);
    chk("R9 A>=N divides by (P+1)N", per, 390);
    chk("R8 err_n set for A>=N", err_n, 1);
    n_val = 11'd0; a_val = 7'd0;
    fp_period(per); fp_period(per);
    chk("R9 N=0 acts as 1", per, 64);
    r_val = 14'd3;
    fr_period(per); fr_period(per);
    chk("R9 R=3 still divides", per, 3);
    cur_req = "R8";
    chk("R8 err_r set for R=3", err_r, 1);
    cur_req = "R9";
    @(negedge osc_clk); r_val = 14'd0;
    repeat (12) @(negedge osc_clk);
    chk("R9 R=0 acts as 1", fr, 1);
    cur_req = "R8";
    n_val = 11'd5; a_val = 7'd2; r_val = 14'd6;
    fp_period(per); fp_period(per);
    chk("R8 err_n clears after good load", err_n, 0);
    fr_period(per);
    chk("R8 err_r clears after good load", err_r, 0);
    cur_req = "R3";
    @(negedge vco_clk); while (!fp) @(negedge vco_clk);
    @(negedge vco_clk);
    chk("R3 fp one cycle wide", fp, 0);
    @(negedge osc_clk); while (!fr) @(negedge osc_clk);
    @(negedge osc_clk);
    chk("R3 fr one cycle wide", fr, 0);

    finish_run();
  end
endmodule